// File: doc/BRIEF.md
# Indirect Byte-Register Access Bridge

This block gives a host access to the byte-wide internal registers of a two-wire serial controller through one 64-bit command word. The host writes the command word with a start flag, a direction flag, an opcode, an extended opcode and a data byte. The bridge decodes the word and performs exactly one internal register read or write. When the access is done it clears the start flag. On a read it also puts the selected register's value in the low byte of the same word.

The host polls the command word until the start flag drops. While an access is in flight the bridge ignores any further write to the command word. A second 64-bit word at its own offset holds an interrupt-enable bit and two bus-line override bits. In this block the serial engine is replaced by a small register file: data, control, clock-high period, clock control and status bytes. The status byte rests at the idle code 0xF8.

Top module: `idx_reg_bridge`

## Requirements
- R1: After synchronous reset, the command word and the interrupt/override word read as zero, and a status read returns 0xF8.
- R2: A host write at offset 0x00 with bit 63 set, accepted while bit 63 is clear, starts an access. Bit 63 reads 1 after the accepting edge and after the next edge. It reads 0 after the second edge following acceptance.
- R3: When bit 56 is set the access is a read. At completion bits 7:0 take the selected register's value, and every other bit except 63 keeps the written value.
- R4: Opcode 4 in bits 60:57 selects the clock-high-period register. A write stores bits 7:0, and a later read returns them.
- R5: With opcode 6, extended opcode 1 in bits 34:32 selects the data register and extended opcode 2 selects the control register, for both reads and writes.
- R6: With opcode 6, extended opcode 3 writes the clock-control register but reads the status register, so a read after such a write still returns the status value.
- R7: With opcode 6, extended opcode 7 resets the controller, with or without bit 56. Data and control clear, status returns to 0xF8, and the clock registers keep their values. A read of this kind returns 0 in bits 7:0.
- R8: Any other opcode or extended opcode completes in the same time without changing any internal register, and a read of it returns 0 in bits 7:0.
- R9: A host write to offset 0x00 while bit 63 is set is ignored.
- R10: A write at offset 0x10 stores only bits 6, 8 and 9, and the other bits read 0. Writes at any other offset change neither word.
- R11: A write at offset 0x00 with bit 63 clear is stored as written and starts no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host word offset |
| host_wdata | input | 64 | Host write data |
| cmd_word | output | 64 | Command/result word (offset 0x00) |
| intr_word | output | 64 | Interrupt/override word (offset 0x10) |

## Verification
On every cycle the assertions check the timing of the start flag:
- it stays set while the access countdown runs;
- it drops on the completion edge;
- the command word holds still when a write lands during an access.

They also check that a controller reset leaves the status byte at idle and the data byte at zero, and that unmapped reads return zero. Only the bench scenarios can show the following:
- the value each opcode and extended-opcode pair reads back after earlier writes;
- that extended opcode 3 writes one register and reads another;
- that the clock registers survive a controller reset;
- the masking of the interrupt/override word.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int WORD_W  = 64;
  localparam int BYTE_W  = 8;
  localparam int VLD_BIT = 63;
  localparam int RD_BIT  = 56;
  localparam int OP_LSB  = 57;
  localparam int OP_W    = 4;
  localparam int EOP_LSB = 32;
  localparam int EOP_W   = 3;

  localparam logic [OP_W-1:0]  OP_CLKHI  = 4'd4;
  localparam logic [OP_W-1:0]  OP_EXT    = 4'd6;
  localparam logic [EOP_W-1:0] EOP_DATA  = 3'd1;
  localparam logic [EOP_W-1:0] EOP_CTL   = 3'd2;
  localparam logic [EOP_W-1:0] EOP_CLK   = 3'd3;
  localparam logic [EOP_W-1:0] EOP_RESET = 3'd7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_CTL,
    SEL_CLKHI,
    SEL_CLKCTL,
    SEL_STAT,
    SEL_RESET
  } sel_e;
endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
  import ibr_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  logic [EOP_W-1:0] eop,
  input  logic             is_read,
  output sel_e             sel
);
  always_comb begin
    sel = SEL_NONE;
    if (op == OP_CLKHI) begin
      sel = SEL_CLKHI;
    end else if (op == OP_EXT) begin
      case (eop)
        EOP_DATA:  sel = SEL_DATA;
        EOP_CTL:   sel = SEL_CTL;
        EOP_CLK:   sel = is_read ? SEL_STAT : SEL_CLKCTL;
        EOP_RESET: sel = SEL_RESET;
        default:   sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ibr_byte_regs.sv
module ibr_byte_regs
  import ibr_pkg::*;
#(
  parameter int              BW        = 8,
  parameter logic [BW-1:0]   IDLE_CODE = 8'hF8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          ctl_rst,
  input  sel_e          sel,
  input  logic [BW-1:0] wbyte,
  output logic [BW-1:0] rbyte
);
  logic [BW-1:0] data_q, ctl_q, clkhi_q, clkctl_q, stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      ctl_q    <= '0;
      clkhi_q  <= '0;
      clkctl_q <= '0;
      stat_q   <= IDLE_CODE;
    end else if (ctl_rst) begin
      data_q <= '0;
      ctl_q  <= '0;
      stat_q <= IDLE_CODE;
    end else if (wr_en) begin
      case (sel)
        SEL_DATA:   data_q   <= wbyte;
        SEL_CTL:    ctl_q    <= wbyte;
        SEL_CLKHI:  clkhi_q  <= wbyte;
        SEL_CLKCTL: clkctl_q <= wbyte;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DATA:   rbyte = data_q;
      SEL_CTL:    rbyte = ctl_q;
      SEL_CLKHI:  rbyte = clkhi_q;
      SEL_CLKCTL: rbyte = clkctl_q;
      SEL_STAT:   rbyte = stat_q;
      default:    rbyte = '0;
    endcase
  end

  // R7: controller reset returns status to idle and clears data
  assert_ctl_reset_idle_R7: assert property (@(posedge clk) disable iff (rst)
    ctl_rst |=> (stat_q == IDLE_CODE) && (data_q == '0));
endmodule

// File: rtl/idx_reg_bridge.sv
module idx_reg_bridge
  import ibr_pkg::*;
#(
  parameter int                ADDR_W     = 5,
  parameter logic [ADDR_W-1:0] CMD_OFS    = 5'h00,
  parameter logic [ADDR_W-1:0] INTR_OFS   = 5'h10,
  parameter int                LATENCY    = 2,
  parameter logic [63:0]       INTR_MASK  = 64'h340,
  parameter logic [7:0]        IDLE_CODE  = 8'hF8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       cmd_word,
  output logic [63:0]       intr_word
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [WORD_W-1:0] cmd_q, intr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done;
  logic              accept;
  sel_e              sel;
  logic [BYTE_W-1:0] rbyte;

  assign done   = (cnt_q == CNT_LAST);
  assign accept = host_we && (host_addr == CMD_OFS) && !cmd_q[VLD_BIT];

  ibr_decode u_dec (
    .op      (cmd_q[OP_LSB +: OP_W]),
    .eop     (cmd_q[EOP_LSB +: EOP_W]),
    .is_read (cmd_q[RD_BIT]),
    .sel     (sel)
  );

  ibr_byte_regs #(.BW(BYTE_W), .IDLE_CODE(IDLE_CODE)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (done && !cmd_q[RD_BIT]),
    .ctl_rst (done && (sel == SEL_RESET)),
    .sel     (sel),
    .wbyte   (cmd_q[BYTE_W-1:0]),
    .rbyte   (rbyte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      cnt_q <= '0;
    end else if (done) begin
      cmd_q[VLD_BIT] <= 1'b0;
      if (cmd_q[RD_BIT]) cmd_q[BYTE_W-1:0] <= rbyte;
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (accept) begin
      cmd_q <= host_wdata;
      if (host_wdata[VLD_BIT]) cnt_q <= CNT_LOAD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) intr_q <= '0;
    else if (host_we && host_addr == INTR_OFS) intr_q <= host_wdata & INTR_MASK;
  end

  assign cmd_word  = cmd_q;
  assign intr_word = intr_q;

  // R2: valid flag stays set while the countdown runs
  assert_valid_held_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> cmd_q[VLD_BIT]);
  // R2: completion edge clears the valid flag
  assert_valid_clear_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !cmd_q[VLD_BIT]);
  // R9: a host write during an access leaves the word untouched
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == CMD_OFS && cmd_q[VLD_BIT] && !done) |=> $stable(cmd_q));
  // R8: unmapped read returns zero
  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (done && cmd_q[RD_BIT] && sel == SEL_NONE) |=> (cmd_q[BYTE_W-1:0] == '0));
endmodule

// File: tb/test_idx_reg_bridge.sv
module test_idx_reg_bridge;
  logic        clk = 0;
  logic        rst = 1;
  logic        host_we = 0;
  logic [4:0]  host_addr = 0;
  logic [63:0] host_wdata = 0;
  logic [63:0] cmd_word, intr_word;

  int total = 0;
  int bad = 0;
  logic [7:0] m_data = 0, m_ctl = 0, m_clkhi = 0, m_stat = 8'hF8;

  always #5 clk = ~clk;

  idx_reg_bridge i_idx_reg_bridge (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .cmd_word(cmd_word), .intr_word(intr_word)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(bit rd, logic [3:0] op, logic [2:0] eop,
                                     logic [7:0] d, logic [63:0] fill);
    logic [63:0] w = fill;
    w[63] = 1'b1; w[60:57] = op; w[56] = rd; w[34:32] = eop; w[7:0] = d;
    return w;
  endfunction

  function automatic logic [7:0] m_read(logic [3:0] op, logic [2:0] eop);
    if (op == 4) return m_clkhi;
    if (op == 6) case (eop)
      3'd1: return m_data;
      3'd2: return m_ctl;
      3'd3: return m_stat;
      default: return 8'h00;
    endcase
    return 8'h00;
  endfunction

  task automatic m_apply(logic [63:0] w);
    if (w[60:57] == 6 && w[34:32] == 7) begin
      m_data = 0; m_ctl = 0; m_stat = 8'hF8;
    end else if (!w[56]) begin
      if (w[60:57] == 4) m_clkhi = w[7:0];
      else if (w[60:57] == 6 && w[34:32] == 1) m_data = w[7:0];
      else if (w[60:57] == 6 && w[34:32] == 2) m_ctl = w[7:0];
    end
  endtask

  task automatic hwrite(logic [4:0] a, logic [63:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic access(string tag, logic [63:0] w);
    logic [63:0] exp = w;
    exp[63] = 1'b0;
    if (w[56]) exp[7:0] = m_read(w[60:57], w[34:32]);
    m_apply(w);
    hwrite(5'h00, w);
    check({tag, " R2 valid after accept"}, 64'(cmd_word[63]), 64'd1);
    @(negedge clk);
    check({tag, " R2 valid mid access"}, 64'(cmd_word[63]), 64'd1);
    @(negedge clk);
    check({tag, " R3 result word"}, cmd_word, exp);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] w;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 cmd reset", cmd_word, 64'd0);
    check("R1 intr reset", intr_word, 64'd0);
    access("R1 status read", mk(1, 6, 3, 8'h00, 64'd0));

    access("R4 clkhi write", mk(0, 4, 0, 8'h5A, 64'h00A0_0000_1234_0000));
    access("R4 clkhi read", mk(1, 4, 0, 8'hFF, 64'd0));
    access("R5 data write", mk(0, 6, 1, 8'h3C, 64'd0));
    access("R5 ctl write", mk(0, 6, 2, 8'hC4, 64'd0));
    access("R5 data read", mk(1, 6, 1, 8'h00, 64'h0011_0000_0000_AB00));
    access("R5 ctl read", mk(1, 6, 2, 8'h00, 64'd0));
    access("R6 clkctl write", mk(0, 6, 3, 8'h1B, 64'd0));
    access("R6 eop3 reads status", mk(1, 6, 3, 8'h00, 64'd0));
    access("R8 unused op write", mk(0, 4'd9, 0, 8'h77, 64'd0));
    access("R8 unused op read", mk(1, 4'd9, 0, 8'h77, 64'd0));
    access("R8 unused eop read", mk(1, 6, 5, 8'h66, 64'd0));
    access("R8 data untouched", mk(1, 6, 1, 8'h00, 64'd0));
    access("R7 reset read", mk(1, 6, 7, 8'h99, 64'd0));
    access("R7 data cleared", mk(1, 6, 1, 8'h00, 64'd0));
    access("R7 ctl cleared", mk(1, 6, 2, 8'h00, 64'd0));
    access("R7 clkhi kept", mk(1, 4, 0, 8'h00, 64'd0));

    // R9: write during access
    w = mk(0, 6, 1, 8'hA5, 64'd0);
    m_apply(w);
    hwrite(5'h00, w);
    @(negedge clk);
    host_we = 1; host_addr = 0; host_wdata = mk(0, 6, 1, 8'h11, 64'd0);
    @(negedge clk);
    host_we = 0;
    check("R9 busy write ignored", cmd_word, {1'b0, w[62:0]});
    access("R9 data kept", mk(1, 6, 1, 8'h00, 64'd0));

    // R11: valid clear
    hwrite(5'h00, 64'h0000_0004_0000_0042 | (64'd6 << 57));
    check("R11 stored no start", cmd_word, 64'h0000_0004_0000_0042 | (64'd6 << 57));
    @(negedge clk); @(negedge clk);
    access("R11 data unchanged", mk(1, 6, 1, 8'h00, 64'd0));

    // R10: interrupt word
    hwrite(5'h10, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R10 intr mask", intr_word, 64'h340);
    w = cmd_word;
    hwrite(5'h08, 64'h1234);
    check("R10 other offset cmd", cmd_word, w);
    check("R10 other offset intr", intr_word, 64'h340);
    hwrite(5'h10, 64'h40);
    check("R10 intr rewrite", intr_word, 64'h40);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [3:0] op;
      logic [2:0] eop;
      int r = $urandom_range(0, 9);
      op  = (r < 4) ? 4'd6 : (r < 7) ? 4'd4 : 4'($urandom_range(0, 15));
      eop = 3'($urandom_range(0, 7));
      if (op == 6 && eop == 7 && $urandom_range(0, 3) != 0) eop = 3'd1;
      w = mk(1'($urandom_range(0, 1)), op, eop, 8'($urandom),
             {32'($urandom), 32'($urandom)} & 64'h00FF_FFF0_FFFF_FF00);
      access("R3 random", w);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule